// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block keeps a small set-associative store of recently used page-table entries so that most virtual-to-physical translations finish without any page-table traffic. A requester offers a virtual address, an access kind (read or write) and whether it runs privileged. The lookup uses only the virtual page number. The low bits of the page number choose a set, and the remaining page-number bits are compared as a tag. On a hit the block answers from the stored entry: either a physical address built from the cached physical page number and the untouched page offset, or a protection fault.

On a miss the block asks an external walker for the entry. A valid returned entry is written into the chosen set, which may evict a resident line, and the response is formed from it. A returned entry marked invalid is not cached, and its fault goes straight back. A flush input empties the whole store in one cycle.

All three data paths use valid/ready. A transfer happens on a clock edge where both are high. The request side accepts only while no walk is in flight and the response register is empty or being drained. A response is held, unchanged, until the consumer takes it. A walk request is held, with a stable page number, until the walker accepts it. The block only accepts walk responses while it is waiting for one.

Top module: `tlb_xlate`

## Requirements
- R1: Reset and a flush each clear every valid bit, so that afterwards any access is a miss and goes to the walker. After reset, req_ready is 1 and rsp_valid and walk_req_valid are 0.
- R2: The page offset is address bits [11:0] and the virtual page number (VPN) is bits [31:12]. The set index is VPN bits [1:0] (address bits [13:12]) and the tag is VPN bits [19:2]. The offset plays no part in lookup. Each set has two ways, and a page is never resident in two ways.
- R3: A hit raises rsp_valid in the cycle after the accepting edge, issues no walk request, and returns paddr = {cached PPN, offset}.
- R4: A miss raises walk_req_valid in the cycle after the accepting edge with walk_vpn equal to the request's VPN. Both are held until walk_req_ready.
- R5: A miss response is valid in the cycle after the walk-response handshake and uses the returned PPN. A valid returned entry is installed, so the next access to that page hits.
- R6: A fault is reported when the entry is invalid, or the page is supervisor-only and the request is not privileged, or a write meets a clear write bit, or a read meets a clear read bit. A faulting response carries paddr 0. The same rules apply to hits and to walked entries.
- R7: A walked entry that is invalid is never installed, so the page walks again on the next access. A valid entry that faults on permissions is installed, and its next access faults without a walk.
- R8: A fill takes the lowest invalid way of its set. If both ways are valid, it takes the way named by that set's round-robin pointer. Each pointer is 0 after reset and advances by one, wrapping, on every fill that overwrites a valid line.
- R9: A flush during an outstanding walk leaves the returned entry uninstalled, but the response is still delivered.
- R10: While rsp_valid is 1 and rsp_ready is 0, paddr and fault stay stable and req_ready is 0.
- R11: A request accepted in the same cycle as a flush is treated as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_super | input | 1 | Requester runs privileged |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Access denied or page invalid |
| walk_req_valid | output | 1 | Walk requested |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_vpn | output | 20 | Page number to walk |
| walk_rsp_valid | input | 1 | Walked entry available |
| walk_rsp_ready | output | 1 | Block waits for a walked entry |
| walk_rsp_ppn | input | 20 | Physical page number of the entry |
| walk_rsp_ok | input | 1 | Entry valid bit |
| walk_rsp_sup | input | 1 | Entry is supervisor-only |
| walk_rsp_rd | input | 1 | Entry allows reads |
| walk_rsp_wr | input | 1 | Entry allows writes |

## Verification
A hit must appear on the response port in the cycle that follows its accepting edge. A miss must appear in the cycle that follows the walker's response handshake. The bench records the cycle number of each of these edges. When rsp_valid first rises for a scoreboard item, the bench compares the current cycle against the recorded edge. Whether a walk took place is judged by counting walker handshakes around each access. Outputs are sampled on the falling edge, so every value checked has settled after the edge that produced it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic sup;
    logic rd;
    logic wr;
  } tlb_perm_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WREQ = 2'd1,
    ST_WRSP = 2'd2
  } tlb_st_e;
endpackage

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_pkg::*;
(
  input  logic      entry_ok,
  input  tlb_perm_t perm,
  input  logic      is_write,
  input  logic      is_super,
  output logic      fault
);
  always_comb begin
    fault = !entry_ok
         || (perm.sup && !is_super)
         || (is_write ? !perm.wr : !perm.rd);
  end
endmodule

// File: rtl/tlb_ways.sv
module tlb_ways
  import tlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 18,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output tlb_perm_t        lk_perm,
  input  logic [IDX_W-1:0] fl_idx,
  output logic [WAYS-1:0]  fl_vld_vec,
  input  logic             fl_en,
  input  logic [WAY_W-1:0] fl_way,
  input  logic [TAG_W-1:0] fl_tag,
  input  logic [PPN_W-1:0] fl_ppn,
  input  tlb_perm_t        fl_perm
);
  logic [WAYS-1:0]  vld    [SETS];
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
  tlb_perm_t        perm_q [SETS][WAYS];
  logic [WAYS-1:0]  match;
  logic             any_vld;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (fl_en) begin
      vld[fl_idx][fl_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_en && !flush) begin
      tag_q[fl_idx][fl_way]  <= fl_tag;
      ppn_q[fl_idx][fl_way]  <= fl_ppn;
      perm_q[fl_idx][fl_way] <= fl_perm;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        lk_ppn  = lk_ppn | ppn_q[lk_idx][w];
        lk_perm = lk_perm | perm_q[lk_idx][w];
      end
    end
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld[s]);
  end

  assign lk_hit     = |match;
  assign fl_vld_vec = vld[fl_idx];

  // R2
  single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R1
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_vld);
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAYS-1:0]  vld_vec,
  input  logic             adv,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] rr [SETS];
  logic             found;
  logic             full;

  always_comb begin
    victim = rr[idx];
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld_vec[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    full = &vld_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr[s] <= '0;
    end else if (adv && full) begin
      rr[idx] <= (rr[idx] == WAY_W'(WAYS - 1)) ? '0 : rr[idx] + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_super,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             walk_req_valid,
  input  logic             walk_req_ready,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_rsp_valid,
  output logic             walk_rsp_ready,
  input  logic [PPN_W-1:0] walk_rsp_ppn,
  input  logic             walk_rsp_ok,
  input  logic             walk_rsp_sup,
  input  logic             walk_rsp_rd,
  input  logic             walk_rsp_wr
);
  tlb_st_e          st_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q, sup_q, drop_q;
  logic             rsp_valid_q, rsp_fault_q;
  logic [PA_W-1:0]  rsp_paddr_q;

  logic [VPN_W-1:0] req_vpn;
  logic             accept, hit_now, hit_fault, walk_fault, walk_done, fill_en;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  tlb_perm_t        lk_perm, walk_perm;
  logic [WAYS-1:0]  fl_vld_vec;
  logic [WAY_W-1:0] victim;

  assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
  assign req_ready = (st_q == ST_IDLE) && (!rsp_valid_q || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign hit_now   = lk_hit && !flush;
  assign walk_perm = '{sup: walk_rsp_sup, rd: walk_rsp_rd, wr: walk_rsp_wr};
  assign walk_done = (st_q == ST_WRSP) && walk_rsp_valid;
  assign fill_en   = walk_done && walk_rsp_ok && !drop_q && !flush;

  assign walk_req_valid = (st_q == ST_WREQ);
  assign walk_rsp_ready = (st_q == ST_WRSP);
  assign walk_vpn       = vpn_q;
  assign rsp_valid      = rsp_valid_q;
  assign rsp_paddr      = rsp_paddr_q;
  assign rsp_fault      = rsp_fault_q;

  tlb_ways #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_ways (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_idx     (req_vpn[IDX_W-1:0]),
    .lk_tag     (req_vpn[VPN_W-1:IDX_W]),
    .lk_hit     (lk_hit),
    .lk_ppn     (lk_ppn),
    .lk_perm    (lk_perm),
    .fl_idx     (vpn_q[IDX_W-1:0]),
    .fl_vld_vec (fl_vld_vec),
    .fl_en      (fill_en),
    .fl_way     (victim),
    .fl_tag     (vpn_q[VPN_W-1:IDX_W]),
    .fl_ppn     (walk_rsp_ppn),
    .fl_perm    (walk_perm)
  );

  tlb_repl #(.SETS(SETS), .WAYS(WAYS)) u_repl (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (vpn_q[IDX_W-1:0]),
    .vld_vec (fl_vld_vec),
    .adv     (fill_en),
    .victim  (victim)
  );

  tlb_perm_chk u_hit_chk (
    .entry_ok (1'b1),
    .perm     (lk_perm),
    .is_write (req_write),
    .is_super (req_super),
    .fault    (hit_fault)
  );

  tlb_perm_chk u_walk_chk (
    .entry_ok (walk_rsp_ok),
    .perm     (walk_perm),
    .is_write (wr_q),
    .is_super (sup_q),
    .fault    (walk_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      vpn_q       <= '0;
      off_q       <= '0;
      wr_q        <= 1'b0;
      sup_q       <= 1'b0;
      drop_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            vpn_q  <= req_vpn;
            off_q  <= req_vaddr[OFF_W-1:0];
            wr_q   <= req_write;
            sup_q  <= req_super;
            drop_q <= 1'b0;
            if (hit_now) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= hit_fault;
              rsp_paddr_q <= hit_fault ? '0 : {lk_ppn, req_vaddr[OFF_W-1:0]};
            end else begin
              st_q <= ST_WREQ;
            end
          end
        end
        ST_WREQ: begin
          if (flush) drop_q <= 1'b1;
          if (walk_req_ready) st_q <= ST_WRSP;
        end
        ST_WRSP: begin
          if (flush) drop_q <= 1'b1;
          if (walk_rsp_valid) begin
            rsp_valid_q <= 1'b1;
            rsp_fault_q <= walk_fault;
            rsp_paddr_q <= walk_fault ? '0 : {walk_rsp_ppn, off_q};
            st_q        <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_hit && !flush) |=> (rsp_valid && !walk_req_valid));

  // R4
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=> (walk_req_valid && $stable(walk_vpn)));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_super = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        walk_req_valid;
  logic        walk_req_ready = 1'b0;
  logic [19:0] walk_vpn;
  logic        walk_rsp_valid = 1'b0;
  logic        walk_rsp_ready;
  logic [19:0] walk_rsp_ppn = '0;
  logic        walk_rsp_ok = 1'b0;
  logic        walk_rsp_sup = 1'b0;
  logic        walk_rsp_rd = 1'b0;
  logic        walk_rsp_wr = 1'b0;

  always #2 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
    .walk_vpn(walk_vpn), .walk_rsp_valid(walk_rsp_valid),
    .walk_rsp_ready(walk_rsp_ready), .walk_rsp_ppn(walk_rsp_ppn),
    .walk_rsp_ok(walk_rsp_ok), .walk_rsp_sup(walk_rsp_sup),
    .walk_rsp_rd(walk_rsp_rd), .walk_rsp_wr(walk_rsp_wr)
  );

  typedef struct {
    logic [31:0] pa;
    logic        flt;
    bit          walked;
  } exp_t;

  exp_t        sbq[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  int          walks = 0;
  int          walk_hs_cyc = 0;
  int          accept_cyc = 0;
  int          stall_req = 0;
  logic [19:0] exp_vpn = '0;
  string       cur_tag = "";
  bit          done = 1'b0;
  bit          live = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic bit pt_ok(logic [19:0] v);   return v[19:16] != 4'hF; endfunction
  function automatic bit pt_sup(logic [19:0] v);  return v[15];            endfunction
  function automatic bit pt_rd(logic [19:0] v);   return !v[14];           endfunction
  function automatic bit pt_wr(logic [19:0] v);   return v[13];            endfunction
  function automatic logic [19:0] pt_ppn(logic [19:0] v); return v ^ 20'h5A5A5; endfunction

  // walker model: accepts after one cycle, answers two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (live && walk_req_valid) begin
        @(negedge clk);
        chk(walk_vpn == exp_vpn, "R4", "walk_vpn", 64'(walk_vpn), 64'(exp_vpn));
        walk_req_ready = 1'b1;
        @(negedge clk);
        walk_req_ready = 1'b0;
        walks++;
        repeat (2) @(negedge clk);
        walk_rsp_valid = 1'b1;
        walk_rsp_ppn   = pt_ppn(exp_vpn);
        walk_rsp_ok    = pt_ok(exp_vpn);
        walk_rsp_sup   = pt_sup(exp_vpn);
        walk_rsp_rd    = pt_rd(exp_vpn);
        walk_rsp_wr    = pt_wr(exp_vpn);
        while (!walk_rsp_ready) @(negedge clk);
        walk_hs_cyc = cyc + 1;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
      end
    end
  end

  // monitor: timing on first appearance, values on handshake
  initial begin
    bit          first = 1'b1;
    bit          prev_ready = 1'b1;
    logic [31:0] prev_pa = '0;
    logic        prev_f = 1'b0;
    int          stall = 0;
    forever begin
      @(negedge clk);
      if (live && rsp_valid) begin
        if (sbq.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected response", 64'(rsp_paddr), 64'd0);
        end else begin
          if (first) begin
            int due;
            due = sbq[0].walked ? walk_hs_cyc : accept_cyc;
            chk(cyc == due, sbq[0].walked ? "R5" : "R3", "response cycle",
                64'(cyc), 64'(due));
            first = 1'b0;
            stall = stall_req;
            stall_req = 0;
          end else if (!prev_ready) begin
            chk(rsp_paddr == prev_pa && rsp_fault == prev_f, "R10", "held response",
                64'({rsp_fault, rsp_paddr}), 64'({prev_f, prev_pa}));
            chk(req_ready == 1'b0, "R10", "req_ready while held", 64'(req_ready), 64'd0);
          end
          if (stall > 0) begin
            rsp_ready = 1'b0;
            stall--;
          end else begin
            rsp_ready = 1'b1;
          end
          prev_ready = rsp_ready;
          prev_pa    = rsp_paddr;
          prev_f     = rsp_fault;
          if (rsp_ready) begin
            chk(rsp_paddr == sbq[0].pa, cur_tag, "paddr", 64'(rsp_paddr), 64'(sbq[0].pa));
            chk(rsp_fault == sbq[0].flt, cur_tag, "fault", 64'(rsp_fault), 64'(sbq[0].flt));
            void'(sbq.pop_front());
            first = 1'b1;
          end
        end
      end
    end
  end

  // mode 0: plain, 1: flush with the request, 2: flush during the walk
  task automatic access(logic [19:0] vpn, logic [11:0] off, bit wr, bit sup,
                        int exp_walks, string tag, int mode = 0, int stall = 0);
    exp_t e;
    int   w0;
    bit   f;
    f = !pt_ok(vpn) || (pt_sup(vpn) && !sup) || (wr ? !pt_wr(vpn) : !pt_rd(vpn));
    e.pa     = f ? 32'd0 : {pt_ppn(vpn), off};
    e.flt    = f;
    e.walked = exp_walks != 0;
    sbq.push_back(e);
    cur_tag   = tag;
    exp_vpn   = vpn;
    stall_req = stall;
    w0 = walks;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_write = wr;
    req_super = sup;
    if (mode == 1) flush = 1'b1;
    while (!req_ready) @(negedge clk);
    accept_cyc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    flush     = 1'b0;
    if (mode == 2) begin
      while (walks == w0) @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
    end
    while (sbq.size() != 0) @(negedge clk);
    chk(walks - w0 == exp_walks, tag, "walk count", 64'(walks - w0), 64'(exp_walks));
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [19:0] PA = 20'h00004, PB = 20'h00008, PC = 20'h0000C;
  localparam logic [19:0] PD = 20'h00010, PE = 20'h00005, PS = 20'h08001;
  localparam logic [19:0] PW = 20'h02002, PR = 20'h04003, PI = 20'hF0002;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(walk_req_valid == 1'b0, "R1", "walk_req_valid after reset", 64'(walk_req_valid), 64'd0);
    live = 1'b1;

    access(PA, 12'h123, 0, 0, 1, "R5");   // miss, install set0 way0
    access(PA, 12'hFFF, 0, 0, 0, "R2");   // offset ignored: hit
    access(PB, 12'h010, 0, 0, 1, "R8");   // set0 way1
    access(PA, 12'h000, 0, 0, 0, "R3");
    access(PB, 12'h444, 0, 0, 0, "R3");
    access(PC, 12'h020, 0, 0, 1, "R8");   // evicts way0 (PA), pointer -> 1
    access(PB, 12'h030, 0, 0, 0, "R8");
    access(PA, 12'h040, 0, 0, 1, "R8");   // evicts way1 (PB), pointer -> 0
    access(PC, 12'h050, 0, 0, 0, "R8");
    access(PB, 12'h060, 0, 0, 1, "R8");   // evicts way0 (PC)
    access(PA, 12'h070, 0, 0, 0, "R8");
    access(PE, 12'h080, 0, 0, 1, "R2");   // other set
    access(PE, 12'h090, 0, 0, 0, "R2");
    access(PA, 12'h0A0, 0, 0, 0, "R2");
    access(PA, 12'h0B0, 1, 0, 0, "R6");   // write to read-only page on a hit
    access(PS, 12'h0C0, 0, 0, 1, "R6");   // supervisor page, user: fault, installed
    access(PS, 12'h0D0, 0, 0, 0, "R7");   // faults again without a walk
    access(PS, 12'h0E0, 0, 1, 0, "R6");   // privileged: allowed
    access(PW, 12'h0F0, 1, 0, 1, "R6");   // writable page
    access(PW, 12'h100, 1, 0, 0, "R3");
    access(PR, 12'h110, 0, 0, 1, "R6");   // read denied
    access(PI, 12'h120, 0, 0, 1, "R6");   // invalid entry
    access(PI, 12'h130, 0, 0, 1, "R7");   // not installed: walks again
    access(PA, 12'h140, 0, 0, 0, "R10", 0, 3);
    pulse_flush();
    access(PA, 12'h150, 0, 0, 1, "R1");
    access(PD, 12'h160, 0, 0, 1, "R9", 2);
    access(PD, 12'h170, 0, 0, 1, "R9");
    access(PA, 12'h180, 0, 0, 1, "R11", 1);
    access(PA, 12'h190, 0, 0, 0, "R11");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule